// File: doc/BRIEF.md
# Bus Access Match Comparator

This block watches every access on a processor bus and produces a one-cycle match pulse when an access meets the condition that software has programmed. The base condition is a full 24-bit address equality. Optional qualifiers can be added to it: the access direction, and one of two variant-specific checks. A data-capable variant compares the bus data against a 16-bit value under a per-bit mask, and can invert that data condition. A size-capable variant compares the access width (byte or word) against a programmed width. A tag mode reduces the condition to the address alone. The break and tag control bits are passed through as qualifiers on the match pulse.

Software programs the comparator through an 8-byte register window. Offset 0 is control, offsets 1 to 3 hold the address (high, medium, low), offsets 4 and 5 hold the data value (high, low), and offsets 6 and 7 hold the data mask (high, low). Register writes are locked out while the surrounding debug logic is armed. The parameter `DATA_CAPABLE` selects the variant: 1 gives the data-capable variant, 0 gives the size-capable variant.

Top module: `bus_match_cmp`

## Requirements
- R1: After reset, every register in the window reads 0x00 and `match`, `match_brk` and `match_tag` are 0.
- R2: The address value is assembled from offset 1 (bits 23:16), offset 2 (bits 15:8) and offset 3 (bits 7:0). When the comparator is enabled and `bus_valid` is high with `bus_addr` equal to that value, `match` is 1 in the following cycle, and only in that cycle.
- R3: Control bit 0 enables the comparator. While it is 0, `match` stays 0.
- R4: `reg_wr` is ignored while `armed` is 1, so the register contents stay as they were. Reads work at any time.
- R5: Data-capable variant: a mask bit of 1 (offsets 6 and 7) includes the corresponding data bit in the comparison, and a mask bit of 0 excludes it. With control bit 6 at 0, the data condition holds when the included bits of `bus_data` equal the value programmed at offsets 4 and 5.
- R6: Data-capable variant: with control bit 6 at 1, the data condition holds when at least one included bit differs.
- R7: Data-capable variant: an all-zero mask makes the data condition true, whatever the value of control bit 6.
- R8: When control bit 2 is 1, `bus_rnw` must equal control bit 3 for a match. When control bit 2 is 0, the direction is ignored.
- R9: Size-capable variant: when control bit 7 is 1, `bus_word` must equal control bit 6 (1 = word) for a match. When control bit 7 is 0, the access width is ignored.
- R10: When control bit 5 (tag) is 1, the data, inversion, size and direction conditions are all ignored, and only the address decides the match.
- R11: `match_brk` equals `match` ANDed with control bit 4, and `match_tag` equals `match` ANDed with control bit 5. Both use the control value of the cycle in which the access was evaluated.
- R12: Control bit 1 always reads 0. In the data-capable variant, control bit 7 also reads 0. In the size-capable variant, offsets 4 to 7 read 0.
- R13: No match is produced for a cycle in which `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| armed | input | 1 | Debug logic armed; blocks register writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset in the window |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_valid | input | 1 | Bus access valid in this cycle |
| bus_addr | input | 24 | Access address |
| bus_data | input | 16 | Access data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match | output | 1 | Registered one-cycle match pulse |
| match_brk | output | 1 | Match qualified by the break bit |
| match_tag | output | 1 | Match qualified by the tag bit |

## Verification
A register write and a bus access can fall in the same clock cycle. The access must be judged against the register contents from before that edge. The bench provokes this case by enabling the comparator, then clearing the enable bit in exactly the cycle that presents a matching access. It expects a match for that access, and no match for an identical access one cycle later. A second case combines a locked write during `armed` with a matching access, and expects the old control value both to read back and to govern the match.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int DATA_BYTES = DATA_W / BYTE_W;
  localparam int REG_AW     = 3;

  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR = 3'd1;
  localparam logic [REG_AW-1:0] OFS_DATA = 3'd4;
  localparam logic [REG_AW-1:0] OFS_MASK = 3'd6;

  // control fields; bit 1 of the register byte is reserved and not stored
  typedef struct packed {
    logic top7;    // size enable (size variant), always 0 (data variant)
    logic mode6;   // size value (size variant), data inversion (data variant)
    logic tag;
    logic brk;
    logic rw_val;
    logic rw_en;
    logic en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_byte(input logic [7:0] b, input bit data_cap);
    ctrl_t c;
    c.top7   = data_cap ? 1'b0 : b[7];
    c.mode6  = b[6];
    c.tag    = b[5];
    c.brk    = b[4];
    c.rw_val = b[3];
    c.rw_en  = b[2];
    c.en     = b[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {c.top7, c.mode6, c.tag, c.brk, c.rw_val, c.rw_en, 1'b0, c.en};
  endfunction

  function automatic logic data_ok(input logic [DATA_W-1:0] bus, input logic [DATA_W-1:0] ref_v,
                                   input logic [DATA_W-1:0] mask, input logic inv);
    logic same;
    if (mask == '0) return 1'b1;
    same = (((bus ^ ref_v) & mask) == '0);
    return inv ? ~same : same;
  endfunction

  function automatic logic size_ok(input logic word, input logic en, input logic val);
    return ~en | (word == val);
  endfunction

  function automatic logic rw_ok(input logic rnw, input logic en, input logic val);
    return ~en | (rnw == val);
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter bit DATA_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] cmp_addr_o,
  output logic [DATA_W-1:0] cmp_data_o,
  output logic [DATA_W-1:0] cmp_mask_o
);
  logic wr_ok;
  assign wr_ok = wr & ~armed;

  ctrl_t ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ok && addr == OFS_CTRL) ctrl_q <= ctrl_from_byte(wdata, DATA_CAPABLE);
  end
  assign ctrl_o = ctrl_q;

  logic [7:0] abyte [ADDR_BYTES];
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_abyte
    localparam logic [REG_AW-1:0] OFS = REG_AW'(OFS_ADDR + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abyte[i] <= '0;
      else if (wr_ok && addr == OFS) abyte[i] <= wdata;
    end
    assign cmp_addr_o[ADDR_W-1-BYTE_W*i -: BYTE_W] = abyte[i];
  end

  if (DATA_CAPABLE) begin : g_data
    logic [7:0] dbyte [DATA_BYTES];
    logic [7:0] mbyte [DATA_BYTES];
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_dbyte
      localparam logic [REG_AW-1:0] DOFS = REG_AW'(OFS_DATA + i);
      localparam logic [REG_AW-1:0] MOFS = REG_AW'(OFS_MASK + i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dbyte[i] <= '0;
          mbyte[i] <= '0;
        end else begin
          if (wr_ok && addr == DOFS) dbyte[i] <= wdata;
          if (wr_ok && addr == MOFS) mbyte[i] <= wdata;
        end
      end
      assign cmp_data_o[DATA_W-1-BYTE_W*i -: BYTE_W] = dbyte[i];
      assign cmp_mask_o[DATA_W-1-BYTE_W*i -: BYTE_W] = mbyte[i];
    end
  end else begin : g_nodata
    assign cmp_data_o = '0;
    assign cmp_mask_o = '0;
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL) rdata = ctrl_to_byte(ctrl_q);
    for (int i = 0; i < ADDR_BYTES; i++)
      if (addr == REG_AW'(OFS_ADDR + i)) rdata = cmp_addr_o[ADDR_W-1-BYTE_W*i -: BYTE_W];
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (addr == REG_AW'(OFS_DATA + i)) rdata = cmp_data_o[DATA_W-1-BYTE_W*i -: BYTE_W];
      if (addr == REG_AW'(OFS_MASK + i)) rdata = cmp_mask_o[DATA_W-1-BYTE_W*i -: BYTE_W];
    end
  end
endmodule

// File: rtl/cmp_eval.sv
module cmp_eval
  import cmp_pkg::*;
#(
  parameter bit DATA_CAPABLE = 1'b1
) (
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rnw,
  input  logic              bus_word,
  output logic              addr_hit,
  output logic              data_hit,
  output logic              size_hit,
  output logic              rw_hit,
  output logic              hit
);
  logic inv;
  logic size_en;
  assign inv     = DATA_CAPABLE ? ctrl.mode6 : 1'b0;
  assign size_en = DATA_CAPABLE ? 1'b0 : ctrl.top7;

  assign addr_hit = (bus_addr == cmp_addr);
  assign data_hit = ctrl.tag | data_ok(bus_data, cmp_data, cmp_mask, inv);
  assign size_hit = ctrl.tag | size_ok(bus_word, size_en, ctrl.mode6);
  assign rw_hit   = ctrl.tag | rw_ok(bus_rnw, ctrl.rw_en, ctrl.rw_val);
  assign hit      = bus_valid & ctrl.en & addr_hit & data_hit & size_hit & rw_hit;
endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
  import cmp_pkg::*;
#(
  parameter bit DATA_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rnw,
  input  logic              bus_word,
  output logic              match,
  output logic              match_brk,
  output logic              match_tag
);
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0] cmp_data;
  logic [DATA_W-1:0] cmp_mask;
  logic addr_hit, data_hit, size_hit, rw_hit, hit;

  cmp_regs #(.DATA_CAPABLE(DATA_CAPABLE)) u_regs (
    .clk(clk), .rst_n(rst_n), .armed(armed), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_o(ctrl_q),
    .cmp_addr_o(cmp_addr), .cmp_data_o(cmp_data), .cmp_mask_o(cmp_mask)
  );

  cmp_eval #(.DATA_CAPABLE(DATA_CAPABLE)) u_eval (
    .ctrl(ctrl_q), .cmp_addr(cmp_addr), .cmp_data(cmp_data), .cmp_mask(cmp_mask),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rnw(bus_rnw), .bus_word(bus_word),
    .addr_hit(addr_hit), .data_hit(data_hit), .size_hit(size_hit),
    .rw_hit(rw_hit), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match     <= 1'b0;
      match_brk <= 1'b0;
      match_tag <= 1'b0;
    end else begin
      match     <= hit;
      match_brk <= hit & ctrl_q.brk;
      match_tag <= hit & ctrl_q.tag;
    end
  end
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker
  import cmp_pkg::*;
#(
  parameter bit DATA_CAPABLE = 1'b1
) (
  input logic  clk,
  input logic  rst_n,
  input logic  armed,
  input logic  reg_wr,
  input ctrl_t ctrl_q,
  input logic  bus_valid,
  input logic  addr_hit,
  input logic  match,
  input logic  match_brk,
  input logic  match_tag
);
  a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_wr) |=> (ctrl_q == $past(ctrl_q)));

  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(ctrl_q.en));

  a_r13_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(bus_valid));

  a_r2_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(addr_hit));

  a_r11_qualifiers: assert property (@(posedge clk) disable iff (!rst_n)
    (match_brk || match_tag) |-> match);

  a_r11_brk_follows: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (match_brk == $past(ctrl_q.brk)));

  a_r12_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    DATA_CAPABLE |-> !ctrl_q.top7);
endmodule

bind bus_match_cmp cmp_checker #(.DATA_CAPABLE(DATA_CAPABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr(reg_wr), .ctrl_q(ctrl_q),
  .bus_valid(bus_valid), .addr_hit(addr_hit), .match(match),
  .match_brk(match_brk), .match_tag(match_tag)
);

// File: tb/sim_bus_match_cmp.sv
`timescale 1ns/1ps
module sim_bus_match_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic armed = 1'b0;
  logic wr0 = 1'b0, wr1 = 1'b0;
  logic [2:0] raddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd0, rd1;
  logic bvalid = 1'b0;
  logic [23:0] baddr = '0;
  logic [15:0] bdata = '0;
  logic brnw = 1'b0, bword = 1'b0;
  logic m0, mb0, mt0, m1, mb1, mt1;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_match_cmp #(.DATA_CAPABLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr(wr0), .reg_addr(raddr),
    .reg_wdata(wdata), .reg_rdata(rd0), .bus_valid(bvalid), .bus_addr(baddr),
    .bus_data(bdata), .bus_rnw(brnw), .bus_word(bword),
    .match(m0), .match_brk(mb0), .match_tag(mt0));

  bus_match_cmp #(.DATA_CAPABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr(wr1), .reg_addr(raddr),
    .reg_wdata(wdata), .reg_rdata(rd1), .bus_valid(bvalid), .bus_addr(baddr),
    .bus_data(bdata), .bus_rnw(brnw), .bus_word(bword),
    .match(m1), .match_brk(mb1), .match_tag(mt1));

  localparam logic [23:0] A = 24'h123456;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] dref;
    logic [15:0] mask;
    logic [23:0] addr;
    logic [15:0] data;
    logic        rnw;
    logic        valid;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  // ctrl bits: 0 enable, 2 rw enable, 3 rw value, 4 break, 5 tag, 6 inversion
  localparam vec_t VECS [NV] = '{
    '{8'h01, 16'h0000, 16'h0000, A,          16'h0000, 1'b0, 1'b1, 1'b1, 8'd2 },  // R2 hit
    '{8'h01, 16'h0000, 16'h0000, A ^ 24'h1,  16'h0000, 1'b0, 1'b1, 1'b0, 8'd2 },  // R2 miss
    '{8'h00, 16'h0000, 16'h0000, A,          16'h0000, 1'b0, 1'b1, 1'b0, 8'd3 },  // R3 disabled
    '{8'h01, 16'h0000, 16'h0000, A,          16'h0000, 1'b0, 1'b0, 1'b0, 8'd13},  // R13 not valid
    '{8'h01, 16'hABCD, 16'hFFFF, A,          16'hABCD, 1'b0, 1'b1, 1'b1, 8'd5 },  // R5 equal
    '{8'h01, 16'hABCD, 16'hFFFF, A,          16'hABCC, 1'b0, 1'b1, 1'b0, 8'd5 },  // R5 differ
    '{8'h01, 16'hABCD, 16'hFF00, A,          16'hAB00, 1'b0, 1'b1, 1'b1, 8'd5 },  // R5 masked low byte
    '{8'h41, 16'hABCD, 16'hFFFF, A,          16'hABCD, 1'b0, 1'b1, 1'b0, 8'd6 },  // R6 equal -> none
    '{8'h41, 16'hABCD, 16'hFFFF, A,          16'hABCC, 1'b0, 1'b1, 1'b1, 8'd6 },  // R6 differ -> hit
    '{8'h41, 16'hABCD, 16'h0000, A,          16'hABCD, 1'b0, 1'b1, 1'b1, 8'd7 },  // R7 empty mask
    '{8'h0D, 16'h0000, 16'h0000, A,          16'h0000, 1'b1, 1'b1, 1'b1, 8'd8 },  // R8 read wanted
    '{8'h0D, 16'h0000, 16'h0000, A,          16'h0000, 1'b0, 1'b1, 1'b0, 8'd8 },  // R8 write seen
    '{8'h6D, 16'hABCD, 16'hFFFF, A,          16'h0000, 1'b0, 1'b1, 1'b1, 8'd10},  // R10 tag address only
    '{8'h6D, 16'hABCD, 16'hFFFF, A ^ 24'h10, 16'h0000, 1'b0, 1'b1, 1'b0, 8'd10}   // R10 tag addr miss
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit inst, input logic [2:0] ofs, input logic [7:0] val);
    raddr = ofs; wdata = val;
    if (inst) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit inst, input logic [2:0] ofs, output logic [7:0] val);
    raddr = ofs;
    #1;
    val = inst ? rd1 : rd0;
  endtask

  task automatic access(input logic [23:0] a, input logic [15:0] d, input logic rnw,
                        input logic word, input logic v);
    baddr = a; bdata = d; brnw = rnw; bword = word; bvalid = v;
    @(negedge clk);
    bvalid = 1'b0;
  endtask

  task automatic set_addr(input bit inst);
    wr(inst, 3'd1, A[23:16]);
    wr(inst, 3'd2, A[15:8]);
    wr(inst, 3'd3, A[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rd(1'b0, 3'(i), v);
      chk({8'h0, v}, 16'h0, "R1 u0 reg");
      rd(1'b1, 3'(i), v);
      chk({8'h0, v}, 16'h0, "R1 u1 reg");
    end
    chk({13'h0, m0, mb0, mt0}, 16'h0, "R1 outputs");

    // R12: reserved and unimplemented bits
    wr(1'b0, 3'd0, 8'hFF); rd(1'b0, 3'd0, v); chk({8'h0, v}, 16'h007D, "R12 data ctrl");
    wr(1'b1, 3'd0, 8'hFF); rd(1'b1, 3'd0, v); chk({8'h0, v}, 16'h00FD, "R12 size ctrl");
    wr(1'b1, 3'd4, 8'h55); rd(1'b1, 3'd4, v); chk({8'h0, v}, 16'h0, "R12 size no data reg");
    wr(1'b1, 3'd7, 8'h55); rd(1'b1, 3'd7, v); chk({8'h0, v}, 16'h0, "R12 size no mask reg");
    wr(1'b0, 3'd0, 8'h00); wr(1'b1, 3'd0, 8'h00);

    // R2: address assembly
    set_addr(1'b0); set_addr(1'b1);
    rd(1'b0, 3'd1, v); chk({8'h0, v}, 16'h0012, "R2 addr high");
    rd(1'b0, 3'd3, v); chk({8'h0, v}, 16'h0056, "R2 addr low");

    // table walk on the data-capable instance
    for (int n = 0; n < NV; n++) begin
      wr(1'b0, 3'd0, VECS[n].ctrl);
      wr(1'b0, 3'd4, VECS[n].dref[15:8]);
      wr(1'b0, 3'd5, VECS[n].dref[7:0]);
      wr(1'b0, 3'd6, VECS[n].mask[15:8]);
      wr(1'b0, 3'd7, VECS[n].mask[7:0]);
      access(VECS[n].addr, VECS[n].data, VECS[n].rnw, 1'b0, VECS[n].valid);
      chk({15'h0, m0}, {15'h0, VECS[n].exp}, $sformatf("R%0d vector %0d", VECS[n].req, n));
      @(negedge clk);
      chk({15'h0, m0}, 16'h0, "R2 single cycle pulse");
    end

    // R11: qualifiers
    wr(1'b0, 3'd6, 8'h00); wr(1'b0, 3'd7, 8'h00);
    wr(1'b0, 3'd0, 8'h31);
    access(A, 16'h0, 1'b0, 1'b0, 1'b1);
    chk({13'h0, m0, mb0, mt0}, 16'h7, "R11 brk and tag set");
    wr(1'b0, 3'd0, 8'h01);
    access(A, 16'h0, 1'b0, 1'b0, 1'b1);
    chk({13'h0, m0, mb0, mt0}, 16'h4, "R11 brk and tag clear");

    // R4: write locked while armed, old control still governs
    armed = 1'b1;
    wr(1'b0, 3'd0, 8'h00);
    rd(1'b0, 3'd0, v); chk({8'h0, v}, 16'h0001, "R4 ctrl unchanged");
    access(A, 16'h0, 1'b0, 1'b0, 1'b1);
    chk({15'h0, m0}, 16'h1, "R4 still enabled");
    armed = 1'b0;

    // same-cycle write and access: old contents decide (R3)
    raddr = 3'd0; wdata = 8'h00; wr0 = 1'b1;
    baddr = A; bvalid = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; bvalid = 1'b0;
    chk({15'h0, m0}, 16'h1, "R3 same-cycle uses old enable");
    access(A, 16'h0, 1'b0, 1'b0, 1'b1);
    chk({15'h0, m0}, 16'h0, "R3 disabled after write");

    // R9: size variant
    wr(1'b1, 3'd0, 8'hC1);
    access(A, 16'h0, 1'b0, 1'b1, 1'b1); chk({15'h0, m1}, 16'h1, "R9 word wanted word seen");
    access(A, 16'h0, 1'b0, 1'b0, 1'b1); chk({15'h0, m1}, 16'h0, "R9 word wanted byte seen");
    wr(1'b1, 3'd0, 8'h01);
    access(A, 16'h0, 1'b0, 1'b0, 1'b1); chk({15'h0, m1}, 16'h1, "R9 size ignored");
    wr(1'b1, 3'd0, 8'hE1);
    access(A, 16'h0, 1'b0, 1'b0, 1'b1); chk({15'h0, m1}, 16'h1, "R10 tag ignores size");
    chk({15'h0, mt1}, 16'h1, "R11 size tag qualifier");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule